// File: doc/BRIEF.md
# Radio Daughterboard Pin Controller with Automatic TX/RX Switching

This block controls thirty-two general-purpose pins that are split into two banks of sixteen. The upper bank serves the transmit side and the lower bank serves the receive side. Software reaches the block through a small word-addressed port. The port has two address spaces: the pin space holds the data, direction and the two source-select registers, and the switching space holds four 32-bit pattern words.

Every pin has a 2-bit source selector. The selector decides what the pin drives when it is an output:
- the software data bit,
- a bit from the pattern chosen by the live radio state,
- a bit of debug bus 0,
- a bit of debug bus 1.

The radio state is decoded from the `tx_active` and `rx_active` inputs with no register in between. This lets antenna switches and amplifier enables follow the radio without software involvement.

Output enables come from the direction register alone. A pin that is an input drives 0 on `pad_out`. Reading the data word returns the pad inputs after a two-stage synchronizer.

Top module: `dbgpio_atr_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0 and `pad_out` is 0, so every pin is an input with the software source selected.
- R2: A write to pin-space word 1 (direction) lands at the next clock edge. `pad_oe[i]` equals direction bit i, where 1 means output, whatever the pin's source selector holds.
- R3: Pin-space word 0 (data) holds the software value. An output pin whose selector is 0 drives its data bit. Transmit-bank pins are bits 31:16 and receive-bank pins are bits 15:0.
- R4: Pin-space word 2 holds the selectors of the transmit-bank pins, with the field for pin 16+k at bits 2k+1:2k. Word 3 holds the selectors of the receive-bank pins, with the field for pin k at bits 2k+1:2k. The selector codes are 0 for the data bit, 1 for the state pattern, 2 for debug bus 0 and 3 for debug bus 1.
- R5: Switching-space words 0, 1, 2 and 3 are the patterns for idle (neither active), transmit only, receive only and both active. An output pin with selector 1 drives its bit of the pattern for the current `tx_active`/`rx_active`, in the same cycle those inputs change.
- R6: A pin whose direction bit is 0 drives 0 on `pad_out`, whatever its source selector holds.
- R7: While the read address is pin-space word 0, `reg_rdata` shows `pad_in` as sampled two rising edges earlier. A change on `pad_in` is not visible after one edge and is visible after the second, for input and output pins alike.
- R8: Reads of pin-space words 1 to 3 and of all four switching-space words return the last value written there. The read is combinational from `reg_sel_atr` and `reg_addr`.
- R9: Selector codes 2 and 3 connect pin i to bit i of `dbg0` and of `dbg1` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_sel_atr | input | 1 | 0 selects the pin space, 1 selects the switching space |
| reg_addr | input | 2 | Word address within the selected space |
| reg_wdata | input | 2*BANK_W | Write data |
| reg_rdata | output | 2*BANK_W | Combinational read data |
| tx_active | input | 1 | Live transmit-active status |
| rx_active | input | 1 | Live receive-active status |
| dbg0 | input | 2*BANK_W | Debug bus 0, bit i for pin i |
| dbg1 | input | 2*BANK_W | Debug bus 1, bit i for pin i |
| pad_in | input | 2*BANK_W | Pad input levels |
| pad_out | output | 2*BANK_W | Pad output values |
| pad_oe | output | 2*BANK_W | Pad output enables, 1 means drive |

## Verification
The bench builds the block with the default `BANK_W` of 16 and `SYNC_STAGES` of 2. This gives the full 32-pin layout, where the 16/16 bank split and the 2-bit field positions of both selector words can be checked pin by pin. The two-stage depth makes the one-edge and two-edge readback points directly observable. Directed steps sweep the four radio states and the four selector codes. They also place a lone debug pin at each bank edge (pins 15 and 16). Random register writes mixed with random status and debug traffic then compare pads and readback against a bench model.

// File: rtl/dbgpio_pkg.sv
package dbgpio_pkg;

    // Per-pin output source codes
    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

    // Radio state; the encoding doubles as the pattern-word index
    typedef enum logic [1:0] {
        RADIO_IDLE = 2'd0,
        RADIO_TX   = 2'd1,
        RADIO_RX   = 2'd2,
        RADIO_FULL = 2'd3
    } radio_state_e;

    // Pin-space word offsets
    localparam logic [1:0] PW_DATA  = 2'd0;
    localparam logic [1:0] PW_DIR   = 2'd1;
    localparam logic [1:0] PW_TXSEL = 2'd2;
    localparam logic [1:0] PW_RXSEL = 2'd3;

    localparam int SEL_W     = 2;
    localparam int N_PATTERN = 4;
    localparam int ADDR_W    = 2;

    function automatic radio_state_e radio_state(input logic tx, input logic rx);
        return radio_state_e'({rx, tx});
    endfunction

endpackage

// File: rtl/dbgpio_sync.sv
module dbgpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbgpio_regfile.sv
module dbgpio_regfile
    import dbgpio_pkg::*;
#(
    parameter int BANK_W = 16,
    localparam int PIN_W = 2 * BANK_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_wr,
    input  logic                                  reg_sel_atr,
    input  logic [ADDR_W-1:0]                     reg_addr,
    input  logic [PIN_W-1:0]                      reg_wdata,
    output logic [PIN_W-1:0]                      reg_rdata,
    input  logic [PIN_W-1:0]                      sync_in,
    output logic [PIN_W-1:0]                      sw_data,
    output logic [PIN_W-1:0]                      dir,
    output logic [SEL_W*PIN_W-1:0]                sel_vec,
    output logic [N_PATTERN-1:0][PIN_W-1:0]       patterns
);
    logic [PIN_W-1:0]                data_q, dir_q, txsel_q, rxsel_q;
    logic [N_PATTERN-1:0][PIN_W-1:0] pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dir_q   <= '0;
            txsel_q <= '0;
            rxsel_q <= '0;
            pat_q   <= '0;
        end else if (reg_wr) begin
            if (reg_sel_atr) begin
                pat_q[reg_addr] <= reg_wdata;
            end else begin
                case (reg_addr)
                    PW_DATA:  data_q  <= reg_wdata;
                    PW_DIR:   dir_q   <= reg_wdata;
                    PW_TXSEL: txsel_q <= reg_wdata;
                    default:  rxsel_q <= reg_wdata;
                endcase
            end
        end
    end

    always_comb begin
        if (reg_sel_atr) begin
            reg_rdata = pat_q[reg_addr];
        end else begin
            case (reg_addr)
                PW_DATA:  reg_rdata = sync_in;
                PW_DIR:   reg_rdata = dir_q;
                PW_TXSEL: reg_rdata = txsel_q;
                default:  reg_rdata = rxsel_q;
            endcase
        end
    end

    assign sw_data  = data_q;
    assign dir      = dir_q;
    // RX pins occupy the low half, so pin i's field sits at [2i+1:2i]
    assign sel_vec  = {txsel_q, rxsel_q};
    assign patterns = pat_q;
endmodule

// File: rtl/dbgpio_atr_pick.sv
module dbgpio_atr_pick
    import dbgpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic                            tx_active,
    input  logic                            rx_active,
    input  logic [N_PATTERN-1:0][PIN_W-1:0] patterns,
    output logic [PIN_W-1:0]                atr_val
);
    radio_state_e st;

    assign st      = radio_state(tx_active, rx_active);
    assign atr_val = patterns[st];
endmodule

// File: rtl/dbgpio_pin_mux.sv
module dbgpio_pin_mux
    import dbgpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic [SEL_W*PIN_W-1:0] sel_vec,
    input  logic [PIN_W-1:0]       dir,
    input  logic [PIN_W-1:0]       sw_data,
    input  logic [PIN_W-1:0]       atr_val,
    input  logic [PIN_W-1:0]       dbg0,
    input  logic [PIN_W-1:0]       dbg1,
    output logic [PIN_W-1:0]       pad_out,
    output logic [PIN_W-1:0]       pad_oe
);
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        pin_src_e src;
        logic     v;

        assign src = pin_src_e'(sel_vec[SEL_W*p +: SEL_W]);

        always_comb begin
            case (src)
                SRC_SW:   v = sw_data[p];
                SRC_ATR:  v = atr_val[p];
                SRC_DBG0: v = dbg0[p];
                default:  v = dbg1[p];
            endcase
        end

        assign pad_out[p] = dir[p] & v;
        assign pad_oe[p]  = dir[p];
    end
endmodule

// File: rtl/dbgpio_atr_ctrl.sv
module dbgpio_atr_ctrl
    import dbgpio_pkg::*;
#(
    parameter int BANK_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = 2 * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel_atr,
    input  logic [1:0]        reg_addr,
    input  logic [PIN_W-1:0]  reg_wdata,
    output logic [PIN_W-1:0]  reg_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [PIN_W-1:0]  dbg0,
    input  logic [PIN_W-1:0]  dbg1,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe
);
    logic [PIN_W-1:0]                sync_in, sw_data, dir, atr_val;
    logic [SEL_W*PIN_W-1:0]          sel_vec;
    logic [N_PATTERN-1:0][PIN_W-1:0] patterns;

    dbgpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    dbgpio_regfile #(.BANK_W(BANK_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel_atr (reg_sel_atr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .sync_in     (sync_in),
        .sw_data     (sw_data),
        .dir         (dir),
        .sel_vec     (sel_vec),
        .patterns    (patterns)
    );

    dbgpio_atr_pick #(.PIN_W(PIN_W)) u_pick (
        .tx_active (tx_active),
        .rx_active (rx_active),
        .patterns  (patterns),
        .atr_val   (atr_val)
    );

    dbgpio_pin_mux #(.PIN_W(PIN_W)) u_mux (
        .sel_vec (sel_vec),
        .dir     (dir),
        .sw_data (sw_data),
        .atr_val (atr_val),
        .dbg0    (dbg0),
        .dbg1    (dbg1),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/dbgpio_atr_chk.sv
module dbgpio_atr_chk #(
    parameter int PIN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_sel_atr,
    input logic [1:0]       reg_addr,
    input logic [PIN_W-1:0] reg_wdata,
    input logic [PIN_W-1:0] reg_rdata,
    input logic [PIN_W-1:0] pad_in,
    input logic [PIN_W-1:0] pad_out,
    input logic [PIN_W-1:0] pad_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: outputs quiet on the first edge after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0));

    // R2: a direction write shows on the enables one cycle later
    a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel_atr && reg_addr == 2'd1) |=> (pad_oe == $past(reg_wdata)));

    // R6: input pins never drive a 1
    a_r6_input_pins_low: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R7: data readback is pad_in delayed by two edges
    a_r7_sync_depth: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !reg_sel_atr && reg_addr == 2'd0) |-> (reg_rdata == $past(pad_in, 2)));

    // R8: a pattern word written is read back at the same address
    a_r8_pattern_readback: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel_atr) ##1 (reg_sel_atr && reg_addr == $past(reg_addr))
        |-> (reg_rdata == $past(reg_wdata)));
endmodule

bind dbgpio_atr_ctrl dbgpio_atr_chk #(.PIN_W(PIN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_sel_atr (reg_sel_atr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
);

// File: tb/dbgpio_atr_ctrl_bench.sv
module dbgpio_atr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_wr, reg_sel_atr;
    logic [1:0]   reg_addr;
    logic [W-1:0] reg_wdata, reg_rdata;
    logic         tx_active, rx_active;
    logic [W-1:0] dbg0, dbg1, pad_in, pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the registers
    logic [W-1:0] m_data, m_dir, m_txsel, m_rxsel;
    logic [W-1:0] m_pat [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgpio_atr_ctrl u_dbgpio_atr_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel_atr(reg_sel_atr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_active(tx_active), .rx_active(rx_active), .dbg0(dbg0), .dbg1(dbg1),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_out();
        logic [W-1:0] r;
        logic [2*W-1:0] sv;
        logic [W-1:0] pat;
        sv  = {m_txsel, m_rxsel};
        pat = m_pat[{rx_active, tx_active}];
        for (int i = 0; i < W; i++) begin
            logic b;
            case (sv[2*i +: 2])
                2'd0: b = m_data[i];
                2'd1: b = pat[i];
                2'd2: b = dbg0[i];
                default: b = dbg1[i];
            endcase
            r[i] = m_dir[i] & b;
        end
        return r;
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic write_reg(input logic atr, input logic [1:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_sel_atr = atr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (atr) m_pat[a] = d;
        else case (a)
            2'd0: m_data  = d;
            2'd1: m_dir   = d;
            2'd2: m_txsel = d;
            default: m_rxsel = d;
        endcase
    endtask

    task automatic read_check(input string req, input logic atr, input logic [1:0] a,
                              input logic [W-1:0] exp);
        reg_sel_atr = atr; reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pads_check(input string req);
        #1;
        check({req, " out"}, pad_out, exp_out());
        check({req, " oe"}, pad_oe, m_dir);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL R1-watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] tmp;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; reg_wr = 1'b0; reg_sel_atr = 1'b0; reg_addr = '0; reg_wdata = '0;
        tx_active = 1'b0; rx_active = 1'b0; dbg0 = '0; dbg1 = '0; pad_in = '0;
        m_data = '0; m_dir = '0; m_txsel = '0; m_rxsel = '0;
        for (int k = 0; k < 4; k++) m_pat[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 out", pad_out, '0);
        check("R1 oe", pad_oe, '0);
        for (int a = 0; a < 4; a++) read_check("R1 pin reg", 1'b0, a[1:0], '0);
        for (int a = 0; a < 4; a++) read_check("R1 pattern reg", 1'b1, a[1:0], '0);

        // R2, R3, R6: TX bank outputs only
        write_reg(1'b0, 2'd0, 32'hA5A5_5A5A);
        write_reg(1'b0, 2'd1, 32'hFFFF_0000);
        check("R2 oe", pad_oe, 32'hFFFF_0000);
        check("R3 tx bank", pad_out, 32'hA5A5_0000);
        write_reg(1'b0, 2'd1, 32'hFFFF_FFFF);
        check("R3 both banks", pad_out, 32'hA5A5_5A5A);

        // R5, R8: pattern words and state sweep
        write_reg(1'b0, 2'd2, 32'h5555_5555);
        write_reg(1'b0, 2'd3, 32'h5555_5555);
        read_check("R8 txsel", 1'b0, 2'd2, 32'h5555_5555);
        write_reg(1'b1, 2'd0, 32'h1111_1111);
        write_reg(1'b1, 2'd1, 32'h2222_2222);
        write_reg(1'b1, 2'd2, 32'h4444_4444);
        write_reg(1'b1, 2'd3, 32'h8888_8888);
        read_check("R8 pattern full", 1'b1, 2'd3, 32'h8888_8888);
        tx_active = 0; rx_active = 0; #1; check("R5 idle", pad_out, 32'h1111_1111);
        tx_active = 1; rx_active = 0; #1; check("R5 tx only", pad_out, 32'h2222_2222);
        tx_active = 0; rx_active = 1; #1; check("R5 rx only", pad_out, 32'h4444_4444);
        tx_active = 1; rx_active = 1; #1; check("R5 full", pad_out, 32'h8888_8888);

        // R6: selectors ignored on input pins
        write_reg(1'b0, 2'd1, 32'h00FF_F000);
        check("R6 masked", pad_out, 32'h0088_8000);

        // R9: debug buses
        write_reg(1'b0, 2'd1, 32'hFFFF_FFFF);
        dbg0 = 32'hC3A5_0F96; dbg1 = 32'h3C5A_F069;
        write_reg(1'b0, 2'd2, 32'hAAAA_AAAA);
        write_reg(1'b0, 2'd3, 32'hAAAA_AAAA);
        check("R9 dbg0", pad_out, 32'hC3A5_0F96);
        write_reg(1'b0, 2'd2, 32'hFFFF_FFFF);
        write_reg(1'b0, 2'd3, 32'hFFFF_FFFF);
        check("R9 dbg1", pad_out, 32'h3C5A_F069);

        // R4: field positions at the bank edge
        dbg0 = '1; dbg1 = '1;
        write_reg(1'b0, 2'd0, '0);
        write_reg(1'b0, 2'd2, 32'h0000_0002);
        write_reg(1'b0, 2'd3, 32'hC000_0000);
        check("R4 pins 16 and 15", pad_out, 32'h0001_8000);

        // R7: two-edge synchronizer readback
        reg_sel_atr = 1'b0; reg_addr = 2'd0;
        pad_in = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        check("R7 one edge", reg_rdata, '0);
        @(posedge clk); @(negedge clk);
        check("R7 two edges", reg_rdata, 32'hDEAD_BEEF);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            tx_active = 1'($urandom); rx_active = 1'($urandom);
            dbg0 = $urandom; dbg1 = $urandom;
            tmp = $urandom;
            write_reg(op[2], op[1:0], tmp);
            if (op == 3'd0) pads_check("R3 random");
            else if (op[2]) begin
                read_check("R8 random pattern", 1'b1, op[1:0], tmp);
                pads_check("R5 random");
            end else begin
                read_check("R8 random pin reg", 1'b0, op[1:0], tmp);
                pads_check("R4 random");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule